// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave end of a serial peripheral bus in front of a small byte-wide nonvolatile store. The store is a 256-byte array held in registers. A host selects the block with an active-low select line, clocks command, address and data bytes in on one data line, and receives read and status bytes on a second line. That output line has a separate enable so that it can be tri-stated. All bus inputs are brought into the system clock domain and their edges are detected there. This means the serial clock must run several times slower than the system clock.

A write does not reach the array straight away. Incoming bytes go into a 16-byte page buffer, and the buffer is committed at the end of a self-timed busy period. That period begins when the select line rises on a byte boundary. A software enable latch gates every change. A 3-bit region code in the status byte names a protected part of the array, and bytes aimed at it are dropped at commit time. A hardware protect pin stops the region code from being rewritten. A hold input pauses a transfer partway through and lets it continue later without losing its place.

Top module: `spiEepromSlave`

## Requirements
- R1: Input bits are taken on rising serial-clock edges, and the output bit changes only after a falling edge. Reads give the same data whether the clock idles low or high.
- R2: While select is high the block is idle, and raising select ends the command. A pending write or status update is committed only if select rises after a whole number of bytes.
- R3: While hold is low, serial clock edges and input bits are ignored and the output enable is low. The bit position and the command are kept, and the transfer carries on correctly once hold goes high.
- R4: Opcode 0x03 followed by an address byte returns bytes from that address upward, MSB first, for as long as select stays low. The address wraps from 0xFF to 0x00.
- R5: Opcode 0x05 returns the status byte, and it repeats the byte for every further byte clocked out. Bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the region code, and bits 7:5 read as zero.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R7: Opcode 0x02 followed by an address takes data bytes into a 16-byte page buffer. When the offset passes the end of the page it wraps to the start of the same page, and a later byte overwrites an earlier one at the same offset.
- R8: If the write-enable latch is clear, a data write (0x02) or status write (0x01) changes nothing and starts no busy period.
- R9: Region codes: 0 protects nothing, 1 protects 0x00-0x0F, 2 protects 0xF0-0xFF, 3 protects 0x00-0x7F, and 4-7 protect the quarter starting at (code-4)*64. Buffered bytes at protected addresses are dropped, and the rest of the page is still written.
- R10: While the protect pin is low, a status write leaves the region code unchanged and starts no busy period.
- R11: Opcode 0x01 with the latch set and the protect pin high loads bits 4:2 of the next byte as the region code. The new code takes effect when the busy period ends.
- R12: A committed write keeps busy high for BUSY_CYCLES system clocks. When the busy period ends, the write-enable latch clears.
- R13: While busy is set, every opcode except 0x05 is ignored. A read then leaves the output disabled, and 0x04 leaves the latch set.
- R14: After reset the status byte is 0x00, every array byte is 0xFF and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low transfer pause |
| wpN | input | 1 | Active-low protect pin for the region code |
| so | output | 1 | Serial data to the host |
| soOe | output | 1 | Output enable for so |

## Verification
A bus input reaches the logic after a two-flop synchronizer and an edge register. An output bit is therefore valid about four system clocks after the falling serial edge that caused it. The bench holds each serial clock level for six system clocks, and it samples so and soOe just before the next rising edge. A busy period begins about four clocks after select rises and ends BUSY_CYCLES clocks later. For that reason the bench reads status immediately to see busy set, and it polls status before checking the array or the latch. The expected array contents, the status bytes and the page wrap all come from a model in the bench, which is driven by seeded random page writes and region codes together with directed cases.

// File: rtl/spiMemPkg.sv
package spiMemPkg;

  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD_DATA = 8'h03;
  localparam logic [7:0] OP_WR_DATA = 8'h02;

  // status byte layout: region code sits in bits 4:2
  localparam int REGION_LO = 2;
  localparam int REGION_HI = 4;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_READ, PH_WRITE, PH_STAT, PH_WSTAT, PH_SKIP
  } phaseT;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setAddr;
    logic bufPush;
    logic statStage;
    logic rdNext;
    logic commitData;
    logic commitStat;
  } ctlStrobeT;

endpackage

// File: rtl/spiMemCtrl.sv
module spiMemCtrl
  import spiMemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       holdN,
  input  logic       wpN,
  input  logic       busy,
  input  logic [7:0] rdData,
  input  logic [7:0] statusByte,
  output ctlStrobeT  strobe,
  output logic [7:0] rxByte,
  output logic       so,
  output logic       soOe
);

  logic [1:0] csQ, sckQ, siQ, holdQ, wpQ;
  logic csSync, sckSync, siSync, holdSync, wpSync;
  logic sckLast, csLast;
  logic active, riseEv, fallEv, byteDone, csRise, cleanEnd;

  phaseT phase, phaseNext;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] txShift;
  logic loadPend, loadSet, wrMode, statHave, soOeR;

  assign csSync   = csQ[1];
  assign sckSync  = sckQ[1];
  assign siSync   = siQ[1];
  assign holdSync = holdQ[1];
  assign wpSync   = wpQ[1];

  assign active   = !csSync && holdSync;
  assign riseEv   = active && sckSync && !sckLast;
  assign fallEv   = active && !sckSync && sckLast;
  assign byteDone = riseEv && (bitCnt == 3'd7);
  assign rxByte   = {rxShift, siSync};
  assign csRise   = csSync && !csLast;
  assign cleanEnd = csRise && (bitCnt == 3'd0);

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    loadSet   = 1'b0;
    if (byteDone) begin
      case (phase)
        PH_CMD: begin
          if (busy && rxByte != OP_RD_STAT) begin
            phaseNext = PH_SKIP;
          end else begin
            case (rxByte)
              OP_SET_WEL: begin strobe.setWel = 1'b1; phaseNext = PH_SKIP; end
              OP_CLR_WEL: begin strobe.clrWel = 1'b1; phaseNext = PH_SKIP; end
              OP_RD_STAT: begin phaseNext = PH_STAT; loadSet = 1'b1; end
              OP_WR_STAT: phaseNext = PH_WSTAT;
              OP_RD_DATA: phaseNext = PH_ADDR;
              OP_WR_DATA: phaseNext = PH_ADDR;
              default:    phaseNext = PH_SKIP;
            endcase
          end
        end
        PH_ADDR: begin
          strobe.setAddr = 1'b1;
          if (wrMode) begin
            phaseNext = PH_WRITE;
          end else begin
            phaseNext = PH_READ;
            loadSet   = 1'b1;
          end
        end
        PH_READ, PH_STAT: loadSet = 1'b1;
        PH_WRITE: strobe.bufPush = 1'b1;
        PH_WSTAT: begin strobe.statStage = 1'b1; phaseNext = PH_SKIP; end
        default: ;
      endcase
    end
    strobe.rdNext     = fallEv && loadPend && (phase == PH_READ);
    strobe.commitData = cleanEnd && (phase == PH_WRITE);
    strobe.commitStat = cleanEnd && statHave && wpSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 2'b11; sckQ <= 2'b00; siQ <= 2'b00; holdQ <= 2'b11; wpQ <= 2'b11;
      sckLast <= 1'b0; csLast <= 1'b1;
      phase <= PH_CMD; bitCnt <= '0; rxShift <= '0; txShift <= '0;
      loadPend <= 1'b0; wrMode <= 1'b0; statHave <= 1'b0; soOeR <= 1'b0;
    end else begin
      csQ   <= {csQ[0], csN};
      sckQ  <= {sckQ[0], sck};
      siQ   <= {siQ[0], si};
      holdQ <= {holdQ[0], holdN};
      wpQ   <= {wpQ[0], wpN};
      sckLast <= sckSync;
      csLast  <= csSync;
      soOeR   <= active && (phase == PH_READ || phase == PH_STAT);
      if (csSync) begin
        phase    <= PH_CMD;
        bitCnt   <= '0;
        loadPend <= 1'b0;
        statHave <= 1'b0;
      end else begin
        phase <= phaseNext;
        if (riseEv) begin
          rxShift <= rxByte[6:0];
          bitCnt  <= bitCnt + 3'd1;
        end
        if (byteDone && phase == PH_CMD) wrMode <= (rxByte == OP_WR_DATA);
        if (strobe.statStage) statHave <= 1'b1;
        if (fallEv) begin
          if (loadPend) begin
            txShift  <= (phase == PH_STAT) ? statusByte : rdData;
            loadPend <= 1'b0;
          end else begin
            txShift <= {txShift[6:0], 1'b0};
          end
        end
        if (loadSet) loadPend <= 1'b1;
      end
    end
  end

  assign so   = txShift[7];
  assign soOe = soOeR;

  // R2: a high select parks the command decoder
  p_idle_on_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> (phase == PH_CMD && bitCnt == 3'd0));

  // R3: hold freezes the transfer position
  p_hold_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!holdSync && !csSync) |=> (csSync || ($stable(bitCnt) && $stable(phase) && $stable(rxShift))));

  // R3: hold releases the output line
  p_hold_hiz_r3: assert property (@(posedge clk) disable iff (!rstN)
    !holdSync |=> !soOe);

  // R1: the output bit moves only after a falling serial edge
  p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(sckLast && !sckSync) |=> $stable(so));

endmodule

// File: rtl/spiMemData.sv
module spiMemData
  import spiMemPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobeT  strobe,
  input  logic [7:0] rxByte,
  output logic [7:0] rdData,
  output logic [7:0] statusByte,
  output logic       busy
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam int CODE_W = REGION_HI - REGION_LO + 1;

  logic [7:0]        mem [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   bufValid;
  logic [ADDR_W-1:0] rdAddr;
  logic [BASE_W-1:0] wrBase;
  logic [PAGE_W-1:0] wrPtr;
  logic [CODE_W-1:0] region, regionStaged;
  logic              welR, busyR, cycStat;
  logic [CNT_W-1:0]  cnt;
  logic              cycleEnd, startData, startStat;

  function automatic logic inRegion(input logic [CODE_W-1:0] code, input logic [ADDR_W-1:0] a);
    case (code)
      3'd0:    return 1'b0;
      3'd1:    return a[ADDR_W-1:PAGE_W] == '0;
      3'd2:    return a[ADDR_W-1:PAGE_W] == '1;
      3'd3:    return !a[ADDR_W-1];
      default: return a[ADDR_W-1 -: 2] == code[1:0];
    endcase
  endfunction

  assign cycleEnd  = busyR && (cnt == CNT_W'(BUSY_CYCLES - 1));
  assign startData = strobe.commitData && welR && !busyR && (|bufValid);
  assign startStat = strobe.commitStat && welR && !busyR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) pageBuf[i] <= '0;
      bufValid <= '0; rdAddr <= '0; wrBase <= '0; wrPtr <= '0;
      region <= '0; regionStaged <= '0;
      welR <= 1'b0; busyR <= 1'b0; cycStat <= 1'b0; cnt <= '0;
    end else begin
      if (strobe.setWel) welR <= 1'b1;
      if (strobe.clrWel) welR <= 1'b0;
      if (strobe.setAddr) begin
        rdAddr   <= rxByte[ADDR_W-1:0];
        wrBase   <= rxByte[ADDR_W-1:PAGE_W];
        wrPtr    <= rxByte[PAGE_W-1:0];
        bufValid <= '0;
      end
      if (strobe.rdNext) rdAddr <= rdAddr + 1'b1;
      if (strobe.bufPush) begin
        pageBuf[wrPtr]  <= rxByte;
        bufValid[wrPtr] <= 1'b1;
        wrPtr           <= wrPtr + 1'b1;
      end
      if (strobe.statStage) regionStaged <= rxByte[REGION_HI:REGION_LO];
      if (startData || startStat) begin
        busyR   <= 1'b1;
        cnt     <= '0;
        cycStat <= startStat;
      end else if (busyR) begin
        cnt <= cnt + 1'b1;
        if (cycleEnd) begin
          busyR <= 1'b0;
          welR  <= 1'b0;
          if (cycStat) begin
            region <= regionStaged;
          end else begin
            for (int i = 0; i < PAGE; i++) begin
              if (bufValid[i] && !inRegion(region, {wrBase, PAGE_W'(i)}))
                mem[{wrBase, PAGE_W'(i)}] <= pageBuf[i];
            end
          end
        end
      end
    end
  end

  assign rdData     = mem[rdAddr];
  assign statusByte = {3'b000, region, welR, busyR};
  assign busy       = busyR;

  // R12: the latch is clear once a busy period ends
  p_wel_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyR) |-> !welR);

  // R13: the latch cannot be set while busy
  p_no_wel_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    busyR |=> !$rose(welR));

  // R8: a busy period starts only with the latch set
  p_start_needs_wel_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyR) |-> $past(welR));

  // R7: the page under write never moves until a new address arrives
  p_page_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.setAddr |=> $stable(wrBase));

endmodule

// File: rtl/spiEepromSlave.sv
module spiEepromSlave
  import spiMemPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  input  logic wpN,
  output logic so,
  output logic soOe
);

  ctlStrobeT  strobe;
  logic [7:0] rxByte, rdData, statusByte;
  logic       busy;

  spiMemCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN), .wpN(wpN),
    .busy(busy), .rdData(rdData), .statusByte(statusByte),
    .strobe(strobe), .rxByte(rxByte), .so(so), .soOe(soOe)
  );

  spiMemData #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .rdData(rdData), .statusByte(statusByte), .busy(busy)
  );

endmodule

// File: tb/spiEepromSlave_test.sv
module spiEepromSlave_test;

  localparam int HALF = 6;
  localparam int GAP  = 12;
  localparam int BUSY = 2000;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, wpN = 1'b1;
  logic so, soOe;

  always #10 clk = ~clk;

  spiEepromSlave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .holdN(holdN), .wpN(wpN), .so(so), .soOe(soOe)
  );

  int checks = 0, errors = 0;
  logic idleHigh = 1'b0;
  logic oeSeen = 1'b0;
  logic [7:0] model [256];
  logic [2:0] mRegion = 3'd0;
  logic mWel = 1'b0;
  logic cycPending = 1'b0;
  logic [7:0] wdat [32];
  logic done = 1'b0;

  function automatic logic [7:0] expStat(input logic busyBit);
    return {3'b000, mRegion, mWel, busyBit};
  endfunction

  function automatic logic prot(input logic [2:0] code, input logic [7:0] a);
    if (code == 3'd0) return 1'b0;
    if (code == 3'd1) return a < 8'h10;
    if (code == 3'd2) return a >= 8'hF0;
    if (code == 3'd3) return a < 8'h80;
    return (a / 64) == (code - 3'd4);
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic csLow();
    sck = idleHigh; waitClk(HALF); csN = 1'b0; waitClk(HALF);
  endtask

  task automatic csHigh();
    sck = idleHigh; waitClk(HALF); csN = 1'b1; waitClk(GAP);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      input int nBits = 8, input int holdAt = -1);
    rx = '0;
    for (int i = 7; i >= 8 - nBits; i--) begin
      sck = 1'b0; si = tx[i];
      waitClk(HALF);
      rx[i] = so;
      oeSeen = oeSeen | soOe;
      if (holdAt == i) begin
        holdN = 1'b0;
        waitClk(HALF);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; si = ~si; waitClk(HALF);
          check("R3 output off in hold", soOe, 1'b0);
          sck = 1'b0; waitClk(HALF);
        end
        si = tx[i];
        holdN = 1'b1;
        waitClk(HALF);
        check("R3 bit kept over hold", so, rx[i]);
      end
      sck = 1'b1;
      waitClk(HALF);
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    csLow(); xfer(op, d); csHigh();
  endtask

  task automatic rdStat(output logic [7:0] s);
    logic [7:0] d;
    csLow(); xfer(8'h05, d); xfer(8'h00, s); csHigh();
  endtask

  task automatic waitReady();
    logic [7:0] s;
    int n = 0;
    s = 8'h01;
    while (s[0] && n < 100) begin rdStat(s); n++; end
    check("R12 busy ends", s[0], 1'b0);
    if (cycPending) begin mWel = 1'b0; cycPending = 1'b0; end
  endtask

  task automatic writeBytes(input logic [7:0] addr, input int n, input int holdAt = -1);
    logic [7:0] d;
    logic [7:0] pb [16];
    logic [15:0] v;
    csLow(); xfer(8'h02, d); xfer(addr, d);
    for (int k = 0; k < n; k++) xfer(wdat[k], d, 8, (k == 0) ? holdAt : -1);
    csHigh();
    v = '0;
    if (mWel && n > 0) begin
      for (int k = 0; k < n; k++) begin
        pb[(addr + k) & 15] = wdat[k];
        v[(addr + k) & 15] = 1'b1;
      end
      for (int o = 0; o < 16; o++) begin
        logic [7:0] a;
        a = {addr[7:4], 4'(o)};
        if (v[o] && !prot(mRegion, a)) model[a] = pb[o];
      end
      cycPending = 1'b1;
    end
  endtask

  task automatic readCheck(input logic [7:0] addr, input int n, input string tag, input int holdAt = -1);
    logic [7:0] d;
    csLow(); xfer(8'h03, d); xfer(addr, d);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d, 8, (k == 0) ? holdAt : -1);
      check(tag, d, model[8'(addr + k)]);
    end
    csHigh();
  endtask

  task automatic setRegion(input logic [2:0] code);
    logic [7:0] d;
    cmd(8'h06); mWel = 1'b1;
    csLow(); xfer(8'h01, d); xfer({3'b000, code, 2'b00}, d); csHigh();
    if (wpN) begin mRegion = code; cycPending = 1'b1; end
    waitReady();
  endtask

  initial begin
    logic [7:0] s, s2, d;
    logic [31:0] seedSink;
    for (int a = 0; a < 256; a++) model[a] = 8'hFF;
    seedSink = $urandom(32'h1234_5678);
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R14 reset state, R5 repeated status bytes
    check("R14 output enable after reset", soOe, 1'b0);
    csLow(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, s2); csHigh();
    check("R14 R5 status after reset", s, 8'h00);
    check("R5 status repeats", s2, 8'h00);
    readCheck(8'h00, 2, "R14 array erased");

    // R6 latch set and clear
    cmd(8'h06); mWel = 1'b1;
    rdStat(s); check("R6 latch set", s, expStat(1'b0));
    cmd(8'h04); mWel = 1'b0;
    rdStat(s); check("R6 latch cleared", s, expStat(1'b0));

    // R8 writes without the latch
    wdat[0] = 8'h11; wdat[1] = 8'h22;
    writeBytes(8'h10, 2);
    rdStat(s); check("R8 no cycle without latch", s, 8'h00);
    readCheck(8'h10, 2, "R8 array untouched");
    csLow(); xfer(8'h01, d); xfer(8'h1C, d); csHigh();
    rdStat(s); check("R8 status write needs latch", s, 8'h00);

    // R12 busy period, R13 commands ignored while busy
    cmd(8'h06); mWel = 1'b1;
    wdat[0] = 8'hA1; wdat[1] = 8'hB2; wdat[2] = 8'hC3;
    writeBytes(8'h20, 3);
    rdStat(s); check("R12 busy with latch", s, 8'h03);
    cmd(8'h04);
    rdStat(s); check("R13 latch clear ignored", s, 8'h03);
    oeSeen = 1'b0;
    csLow(); xfer(8'h03, d); xfer(8'h20, d); xfer(8'h00, d); csHigh();
    check("R13 read ignored while busy", oeSeen, 1'b0);
    waitReady();
    rdStat(s); check("R12 latch cleared after cycle", s, 8'h00);
    readCheck(8'h20, 3, "R7 committed bytes");

    // R7 page wrap with overwrite
    cmd(8'h06); mWel = 1'b1;
    for (int k = 0; k < 20; k++) wdat[k] = 8'(8'h40 + k * 3);
    writeBytes(8'h3C, 20);
    waitReady();
    readCheck(8'h30, 16, "R7 page wrap");

    // R4 sequential read through the top of the array
    cmd(8'h06); mWel = 1'b1;
    wdat[0] = 8'h5A; wdat[1] = 8'hA5;
    writeBytes(8'hFE, 2);
    waitReady();
    readCheck(8'hFE, 4, "R4 address wrap");

    // R1 clock idling high
    idleHigh = 1'b1;
    readCheck(8'h3C, 3, "R1 idle-high read");
    rdStat(s); check("R1 idle-high status", s, 8'h00);
    idleHigh = 1'b0;

    // R3 hold during a read and during a write
    readCheck(8'h30, 2, "R3 read across hold", 4);
    cmd(8'h06); mWel = 1'b1;
    wdat[0] = 8'h96;
    writeBytes(8'h60, 1, 3);
    waitReady();
    readCheck(8'h60, 1, "R3 write across hold");

    // R2 select raised partway through a byte
    cmd(8'h06); mWel = 1'b1;
    csLow(); xfer(8'h02, d); xfer(8'h50, d); xfer(8'hA5, d); xfer(8'hFF, d, 4); csHigh();
    rdStat(s); check("R2 no commit on partial byte", s, expStat(1'b0));
    readCheck(8'h50, 1, "R2 array untouched");
    cmd(8'h04); mWel = 1'b0;

    // R10 protect pin blocks region changes
    wpN = 1'b0;
    cmd(8'h06); mWel = 1'b1;
    csLow(); xfer(8'h01, d); xfer(8'h0C, d); csHigh();
    rdStat(s); check("R10 region held by pin", s, expStat(1'b0));
    wpN = 1'b1;
    cmd(8'h04); mWel = 1'b0;

    // R9 R11 random regions and page writes
    for (int it = 0; it < 8; it++) begin
      logic [2:0] code;
      logic [7:0] addr;
      int n;
      code = 3'($urandom % 8);
      if (it == 0) code = 3'd4;
      if (it == 1) code = 3'd2;
      setRegion(code);
      rdStat(s); check("R11 region loaded", s, expStat(1'b0));
      addr = 8'($urandom % 256);
      if (it == 0) addr = 8'h38;
      if (it == 1) addr = 8'hF8;
      n = 1 + int'($urandom % 20);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      cmd(8'h06); mWel = 1'b1;
      writeBytes(addr, n);
      waitReady();
      rdStat(s); check("R12 latch cleared", s, expStat(1'b0));
      readCheck({addr[7:4], 4'h0}, 16, "R9 protected page write");
    end
    setRegion(3'd0);
    readCheck(8'h00, 258, "R4 full sweep with wrap");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 195000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired, actual %0d expected completion", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule